// File: doc/BRIEF.md
# SPI Register-Access Master with Ready Polling

This block is the host side of a register-access link over SPI. A request names a direction, a 24-bit register address and a length of 1 to 64 bytes. The block frames the request as a four-byte header on MOSI. It then watches bit 0 of the byte shifted in on MISO at the same time as the last header byte. If that bit is clear, the block clocks further filler bytes until a received byte carries bit 0 set. Only after that byte does it move the data: bytes from the write stream go out on MOSI, or bytes are captured from MISO into the read stream.

Software or a sequencer drives the plain command pins and receives a one-cycle `done` pulse with an `err` flag. Write data enters and read data leaves on valid/ready byte streams. Back-pressure on either stream stalls SCLK between bytes while chip-select stays asserted. A byte is only clocked when its write byte is present, or when the read holding register is empty. A read byte stays on `rd_data` until `rd_ready` accepts it. The SCLK rate is set by `cfg_div`. `cfg_wait_max` bounds how many filler bytes may be spent waiting for the target to become ready.

Top module: `spireg_master`

## Requirements
- R1: Header byte 0 carries 1 in bit 7 for a read and 0 for a write, 0 in bit 6, and the length minus one in bits 5..0. Header bytes 1, 2 and 3 carry the address most significant byte first.
- R2: When bit 0 of the MISO byte received during header byte 3 is 1, the data phase begins with the very next byte, and no filler bytes are clocked.
- R3: When that bit is 0, the master clocks 0x00 filler bytes one at a time and tests bit 0 of each received byte. The data phase begins on the byte after the first one with bit 0 set.
- R4: In a write, exactly the requested number of stream bytes is sent, in arrival order, starting on the byte after the ready flag. `wr_ready` is high only during the write data phase, and a timed-out write consumes no stream bytes.
- R5: In a read, the requested number of MISO bytes is delivered on the read stream in order, starting with the byte after the ready flag, while MOSI carries 0x00. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low.
- R6: No ready test is made during the data phase: the value of bit 0 in data bytes has no effect on the byte count. Lengths of 1 and 64 bytes are supported.
- R7: SCLK idles low. MOSI changes only while SCLK is low, MISO is sampled on the rising edge, bits are sent MSB first, and each SCLK high phase lasts `cfg_div`+1 clock cycles.
- R8: Chip-select stays low without a break from the first header bit to the last data bit. Between transactions it is high for at least 2*(`cfg_div`+1) clock cycles.
- R9: If `cfg_wait_max` filler bytes have all returned bit 0 clear, the transaction ends with `err` = 1 after 4+`cfg_wait_max` bytes. A value of 0 makes a clear bit 0 in header byte 3 an immediate timeout.
- R10: `cmd_ready` is high only while idle. Each transaction ends with a one-cycle `done` pulse, and `err` is valid in that cycle: 0 on success and 1 on timeout.
- R11: After reset, and after a reset during a transfer, chip-select is high, SCLK is low, `cmd_ready` is 1, and `done` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | SCLK half period in clock cycles, minus one |
| cfg_wait_max | input | WAIT_W | Limit on filler bytes spent waiting for the ready flag |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Master idle and able to take a request |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 24 | Register address |
| cmd_len_m1 | input | 6 | Transfer length minus one |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Write stream byte taken on this edge when valid |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read stream byte present |
| rd_ready | input | 1 | Read stream consumer accepts the byte |
| rd_data | output | 8 | Read stream byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Timeout flag, valid with done |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to target |
| spi_miso | input | 1 | Serial data from target |
| spi_cs_n | output | 1 | Active-low chip-select |

## Verification
A controller stuck in the wrong phase shows up within one byte time. It appears as a wrong total byte count seen by the target model, as non-zero filler, or as a data byte shifted by one position relative to the ready flag. An off-by-one in the wait counter changes the length of a timed-out transaction by one byte, and it turns the boundary case that succeeds on the last allowed filler byte into an error. A broken divider or a broken chip-select sequencer is caught on the first SCLK high phase or at the first chip-select fall after a transaction.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int LEN_W  = 6;
  localparam int ADDR_W = 24;
  localparam logic [7:0] FILL_BYTE = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HDR,
    ST_WAIT,
    ST_DATA,
    ST_HOLD,
    ST_GAP
  } ctl_state_t;
endpackage

// File: rtl/spireg_tick.sv
module spireg_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt >= div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt >= div);
endmodule

// File: rtl/spireg_shift.sv
module spireg_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);
  logic [7:0] tx_sh;
  logic [2:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
      sclk    <= 1'b0;
      tx_sh   <= '0;
      bit_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        tx_sh   <= tx_byte;
        bit_cnt <= '0;
        sclk    <= 1'b0;
      end else if (busy && tick) begin
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sh   <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign mosi = tx_sh[7];
endmodule

// File: rtl/spireg_ctrl.sv
module spireg_ctrl
  import spireg_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len_m1,
  input  logic [WAIT_W-1:0] cfg_wait_max,
  output logic              cmd_ready,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              err,
  output logic              cs_n,
  output logic              active,
  input  logic              sh_busy,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic              sh_start,
  output logic [7:0]        sh_tx
);
  ctl_state_t         st;
  logic               is_rd;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   len_q;
  logic [1:0]         hdr_idx;
  logic [WAIT_W-1:0]  wait_cnt;
  logic [LEN_W-1:0]   data_cnt;
  logic               gap_cnt;
  logic               err_pend;
  logic [7:0]         hdr_byte;
  logic               slot_free;
  logic [WAIT_W:0]    wait_next;
  logic               wait_expired;

  always_comb begin
    case (hdr_idx)
      2'd0:    hdr_byte = {is_rd, 1'b0, len_q};
      2'd1:    hdr_byte = addr_q[23:16];
      2'd2:    hdr_byte = addr_q[15:8];
      default: hdr_byte = addr_q[7:0];
    endcase
  end

  assign slot_free    = !sh_busy && !sh_done;
  assign wait_next    = {1'b0, wait_cnt} + (WAIT_W+1)'(1);
  assign wait_expired = wait_next >= {1'b0, cfg_wait_max};

  assign cmd_ready = (st == ST_IDLE);
  assign active    = (st != ST_IDLE);
  assign wr_ready  = (st == ST_DATA) && !is_rd && slot_free;

  always_comb begin
    sh_start = 1'b0;
    sh_tx    = FILL_BYTE;
    case (st)
      ST_HDR: begin
        sh_start = slot_free;
        sh_tx    = hdr_byte;
      end
      ST_WAIT: sh_start = slot_free;
      ST_DATA: begin
        if (is_rd) begin
          sh_start = slot_free && !rd_valid;
        end else begin
          sh_start = slot_free && wr_valid;
          sh_tx    = wr_data;
        end
      end
      default: sh_start = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      is_rd    <= 1'b0;
      addr_q   <= '0;
      len_q    <= '0;
      hdr_idx  <= '0;
      wait_cnt <= '0;
      data_cnt <= '0;
      gap_cnt  <= 1'b0;
      err_pend <= 1'b0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          is_rd    <= cmd_read;
          addr_q   <= cmd_addr;
          len_q    <= cmd_len_m1;
          hdr_idx  <= '0;
          wait_cnt <= '0;
          data_cnt <= '0;
          err_pend <= 1'b0;
          cs_n     <= 1'b0;
          st       <= ST_SETUP;
        end
        ST_SETUP: if (tick) st <= ST_HDR;
        ST_HDR: if (sh_done) begin
          if (hdr_idx == 2'd3) begin
            if (sh_rx[0])                st <= ST_DATA;
            else if (cfg_wait_max == '0) begin
              err_pend <= 1'b1;
              st       <= ST_HOLD;
            end else                     st <= ST_WAIT;
          end else begin
            hdr_idx <= hdr_idx + 1'b1;
          end
        end
        ST_WAIT: if (sh_done) begin
          if (sh_rx[0])          st <= ST_DATA;
          else if (wait_expired) begin
            err_pend <= 1'b1;
            st       <= ST_HOLD;
          end else               wait_cnt <= wait_cnt + 1'b1;
        end
        ST_DATA: if (sh_done) begin
          if (is_rd) begin
            rd_data  <= sh_rx;
            rd_valid <= 1'b1;
          end
          if (data_cnt == len_q) st <= ST_HOLD;
          else                   data_cnt <= data_cnt + 1'b1;
        end
        ST_HOLD: if (tick) begin
          cs_n    <= 1'b1;
          gap_cnt <= 1'b0;
          st      <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (gap_cnt) begin
            done <= 1'b1;
            err  <= err_pend;
            st   <= ST_IDLE;
          end else begin
            gap_cnt <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spireg_master.sv
module spireg_master
  import spireg_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [WAIT_W-1:0] cfg_wait_max,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_read,
  input  logic [23:0]       cmd_addr,
  input  logic [5:0]        cmd_len_m1,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              err,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  logic       tick;
  logic       active;
  logic       sh_busy;
  logic       sh_done;
  logic       sh_start;
  logic [7:0] sh_tx;
  logic [7:0] sh_rx;

  spireg_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (active),
    .div   (cfg_div),
    .tick  (tick)
  );

  spireg_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .miso    (spi_miso),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi)
  );

  spireg_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .cmd_valid    (cmd_valid),
    .cmd_read     (cmd_read),
    .cmd_addr     (cmd_addr),
    .cmd_len_m1   (cmd_len_m1),
    .cfg_wait_max (cfg_wait_max),
    .cmd_ready    (cmd_ready),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .wr_ready     (wr_ready),
    .rd_ready     (rd_ready),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .done         (done),
    .err          (err),
    .cs_n         (spi_cs_n),
    .active       (active),
    .sh_busy      (sh_busy),
    .sh_done      (sh_done),
    .sh_rx        (sh_rx),
    .sh_start     (sh_start),
    .sh_tx        (sh_tx)
  );
endmodule

// File: rtl/spireg_checker.sv
module spireg_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cfg_div,
  input logic             cmd_ready,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data,
  input logic             done,
  input logic             spi_sclk,
  input logic             spi_mosi,
  input logic             spi_cs_n
);
  localparam int CW = DIV_W + 3;
  logic [CW-1:0] cs_hi_cnt;
  logic [CW-1:0] sclk_hi_cnt;
  logic [CW-1:0] period;

  assign period = CW'(cfg_div) + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hi_cnt   <= '1;
      sclk_hi_cnt <= '0;
    end else begin
      if (!spi_cs_n)          cs_hi_cnt <= '0;
      else if (cs_hi_cnt != '1) cs_hi_cnt <= cs_hi_cnt + 1'b1;
      if (spi_sclk) sclk_hi_cnt <= sclk_hi_cnt + 1'b1;
      else          sclk_hi_cnt <= '0;
    end
  end

  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> cs_hi_cnt >= (period << 1));

  p_sclk_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |-> sclk_hi_cnt == period);

  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !cmd_ready);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_wr_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !spi_cs_n);
endmodule

bind spireg_master spireg_checker #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_div   (cfg_div),
  .cmd_ready (cmd_ready),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .done      (done),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n)
);

// File: tb/tb_spireg_master.sv
module tb_spireg_master;
  typedef struct packed {
    logic        rd;
    logic [23:0] addr;
    logic [5:0]  lenm1;
    logic [7:0]  stall;
    logic [7:0]  wmax;
    logic [7:0]  div;
    logic        experr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 24'hABCDEF, 6'd3,  8'd0,  8'd8, 8'd0, 1'b0},
    '{1'b1, 24'h123456, 6'd3,  8'd3,  8'd8, 8'd1, 1'b0},
    '{1'b0, 24'h00D40F, 6'd0,  8'd2,  8'd5, 8'd2, 1'b0},
    '{1'b1, 24'hFFFFFF, 6'd63, 8'd0,  8'd4, 8'd0, 1'b0},
    '{1'b0, 24'h000001, 6'd63, 8'd1,  8'd2, 8'd0, 1'b0},
    '{1'b1, 24'h800000, 6'd1,  8'd10, 8'd6, 8'd1, 1'b1},
    '{1'b0, 24'h5A5A5A, 6'd7,  8'd9,  8'd0, 8'd0, 1'b1},
    '{1'b1, 24'h010203, 6'd0,  8'd5,  8'd5, 8'd3, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic [7:0] cfg_wait_max = 8'd4;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic cmd_read = 1'b0;
  logic [23:0] cmd_addr = '0;
  logic [5:0] cmd_len_m1 = '0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic done, err;
  logic spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b0;

  always #5 clk = ~clk;

  spireg_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_wait_max(cfg_wait_max),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_len_m1(cmd_len_m1),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .err(err),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  int nchk = 0;
  int nerr = 0;

  // target model and stream agents state
  int cyc = 0;
  int cur_stall = 0;
  int cur_div = 0;
  logic [7:0] mb [0:127];
  int nb = 0;
  int bitk = 0;
  logic [7:0] sh = '0;
  logic cs_d = 1'b1;
  logic sclk_d = 1'b0;
  int cs_falls = 0;
  int hi_run = 0;
  int hi_bad = 0;
  int wr_idx = 0;
  int rd_cnt = 0;
  logic [7:0] rd_buf [0:255];

  function automatic logic [7:0] wpat(input int n);
    return 8'((n * 29) + 7);
  endfunction

  function automatic logic [7:0] rdpat(input int i);
    return 8'((i * 37) + 92);
  endfunction

  function automatic logic [7:0] resp(input int k);
    if (k < 3) return 8'hA5;
    if (k < 3 + cur_stall) return 8'h00;
    if (k == 3 + cur_stall) return 8'h81;
    return rdpat(k - 4 - cur_stall);
  endfunction

  always @(negedge clk) begin
    cyc = cyc + 1;
    rd_ready = (cyc % 3) != 1;
    if (rd_valid && rd_ready) begin
      rd_buf[rd_cnt % 256] = rd_data;
      rd_cnt = rd_cnt + 1;
    end
    wr_valid = (cyc % 5) != 2;
    wr_data = wpat(wr_idx);
    if (wr_valid && wr_ready) wr_idx = wr_idx + 1;
    if (cs_d && !spi_cs_n) begin
      nb = 0;
      bitk = 0;
      spi_miso = resp(0)[7];
      cs_falls = cs_falls + 1;
    end else if (!spi_cs_n) begin
      if (!sclk_d && spi_sclk) sh = {sh[6:0], spi_mosi};
      if (sclk_d && !spi_sclk) begin
        bitk = bitk + 1;
        if (bitk == 8) begin
          if (nb < 128) mb[nb] = sh;
          nb = nb + 1;
          bitk = 0;
        end
        spi_miso = resp(nb)[7 - bitk];
      end
    end
    if (spi_sclk) hi_run = hi_run + 1;
    else if (sclk_d) begin
      if (hi_run != cur_div + 1) hi_bad = hi_bad + 1;
      hi_run = 0;
    end
    cs_d = spi_cs_n;
    sclk_d = spi_sclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      nerr = nerr + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_read = v.rd;
    cmd_addr = v.addr;
    cmd_len_m1 = v.lenm1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int rb, wb, cf, hb, len, w, exp_nb, bad, n;
    logic got_err;
    cur_stall = int'(v.stall);
    cur_div = int'(v.div);
    cfg_div = v.div;
    cfg_wait_max = v.wmax;
    len = int'(v.lenm1) + 1;
    @(negedge clk);
    rb = rd_cnt; wb = wr_idx; cf = cs_falls; hb = hi_bad;
    issue(v);
    repeat (3) @(negedge clk);
    chk(!cmd_ready && !spi_cs_n, "R10", "cmd_ready low while busy",
        int'(cmd_ready), 0);
    n = 0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n = n + 1;
    end
    chk(done, "R10", "done pulse seen", int'(done), 1);
    got_err = err;
    chk(got_err == v.experr, v.experr ? "R9" : "R10", "err with done",
        int'(got_err), int'(v.experr));
    repeat (12) @(negedge clk);
    w = v.experr ? int'(v.wmax) : int'(v.stall);
    exp_nb = v.experr ? 4 + int'(v.wmax) : 4 + int'(v.stall) + len;
    chk(nb == exp_nb, v.experr ? "R9" : (v.stall == 0 ? "R2" : "R3"),
        "bytes clocked", nb, exp_nb);
    chk(mb[0] == {v.rd, 1'b0, v.lenm1}, "R1", "header byte 0",
        int'(mb[0]), int'({v.rd, 1'b0, v.lenm1}));
    chk({mb[1], mb[2], mb[3]} == v.addr, "R1", "header address",
        int'({mb[1], mb[2], mb[3]}), int'(v.addr));
    bad = 0;
    for (int i = 0; i < w; i++) if (mb[4 + i] != 8'h00) bad = bad + 1;
    chk(bad == 0, "R3", "filler bytes zero", bad, 0);
    if (v.rd) begin
      chk(wr_idx == wb, "R4", "no write bytes taken in read", wr_idx - wb, 0);
      if (!v.experr) begin
        chk(rd_cnt - rb == len, "R6", "read byte count", rd_cnt - rb, len);
        bad = 0;
        for (int i = 0; i < len; i++) begin
          if (rd_buf[(rb + i) % 256] != rdpat(i)) bad = bad + 1;
          if (mb[4 + int'(v.stall) + i] != 8'h00) bad = bad + 1;
        end
        chk(bad == 0, "R5", "read data and zero MOSI", bad, 0);
      end else begin
        chk(rd_cnt == rb, "R9", "no read bytes after timeout", rd_cnt - rb, 0);
      end
    end else begin
      chk(wr_idx - wb == (v.experr ? 0 : len), "R4", "write bytes taken",
          wr_idx - wb, v.experr ? 0 : len);
      if (!v.experr) begin
        bad = 0;
        for (int i = 0; i < len; i++)
          if (mb[4 + int'(v.stall) + i] != wpat(wb + i)) bad = bad + 1;
        chk(bad == 0, "R4", "write data order", bad, 0);
      end
    end
    chk(cs_falls - cf == 1, "R8", "single chip-select assertion",
        cs_falls - cf, 1);
    chk(hi_bad == hb, "R7", "SCLK high phase length", hi_bad - hb, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr = nerr + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(spi_cs_n && !spi_sclk && cmd_ready && !done && !rd_valid, "R11",
        "reset state", int'({spi_cs_n, spi_sclk, cmd_ready, done, rd_valid}),
        5'b10100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // reset in the middle of a read, then recover
    cur_stall = 3; cur_div = 1; cfg_div = 8'd1; cfg_wait_max = 8'd8;
    issue(VECS[1]);
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(spi_cs_n && !spi_sclk && cmd_ready && !rd_valid, "R11",
        "reset mid-transfer", int'({spi_cs_n, spi_sclk, cmd_ready, rd_valid}),
        4'b1010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_vec(VECS[0]);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule